// File: doc/BRIEF.md
# Descriptor Ring Index Tracker

This block keeps the bookkeeping for the two descriptor rings of a DMA-driven Ethernet MAC: a transmit ring, which software fills and hardware drains, and a receive ring, which hardware fills and software drains. Each ring has a produce and a consume index that wrap at a programmable bound. The bound is written as the number of entries minus one. Software moves the index it owns through a small register port. Hardware moves the other index with a completion strobe. The block raises full and empty flags for both rings.

Descriptors live in small internal memories that stand in for the fetch path. Each slot holds a buffer pointer and a control word. For the slot that hardware is currently working on, the block decodes the control word into a byte length (the stored size field plus one), a last-fragment flag on transmit and an interrupt request on receive. When hardware finishes a slot, the block stores a status entry for it. A transmit entry is one word. A receive entry is two words: a status word and a hash/CRC word. Software reads these entries back through the register port.

The register port is a valid/write/address/data bus. A read returns its data one cycle after the request. Hardware drives `tx_hw_done` and `rx_hw_done` and reads the decoded outputs.

Top module: `dring_tracker`

## Requirements
- R1: After a synchronous reset, all four indices are 0, both last-index registers read DEPTH-1, both rings report empty and neither reports full. The flag register (offset 0x06) reads bit0 transmit-full, bit1 transmit-empty, bit2 receive-full, bit3 receive-empty, so after reset it reads 0xA.
- R2: An index that holds the programmed last-index value moves to 0 on its next advance.
- R3: On transmit, software writes the produce index at offset 0x01. A completion strobe on `tx_hw_done` advances the consume index. A write to the consume index at offset 0x02 has no effect.
- R4: The receive ring is empty when its produce and consume indices are equal. It is full when the produce index, advanced once, would equal the consume index. A receive completion while the ring is full is ignored.
- R5: The transmit ring uses the same full and empty rules as the receive ring. A transmit completion while the ring is empty is ignored.
- R6: The transmit control word is written at 0x40+slot. Bits 10:0 hold the byte length minus one, and bit 30 marks the last fragment. For the slot at the transmit consume index, `tx_buf_len` shows the length plus one, `tx_last_frag` shows bit 30, and `tx_buf_ptr` shows the pointer written at 0x20+slot.
- R7: The receive control word is written at 0x80+slot and the receive pointer at 0x60+slot. Bits 10:0 hold the buffer length minus one, and bit 31 requests an interrupt. For the slot at the receive produce index, `rx_buf_len`, `rx_irq_req` and `rx_buf_ptr` show these values. When that slot completes, `rx_irq` pulses if bit 31 was set.
- R8: A transmit completion stores `tx_hw_status` at the consume slot, readable at 0xA0+slot. A receive completion stores `rx_hw_status` and `rx_hw_crc` at the produce slot, readable at 0xC0+slot and 0xE0+slot.
- R9: After a receive completion, the receive status is stored at the first clock edge and the produce index advances at the next edge. `rx_done` pulses for one cycle in step with the advance.
- R10: `rx_err` pulses together with `rx_done` when the stored status ANDed with 0x1B800000 is nonzero. Bit 26, the range error, does not count.
- R11: A software write of its own index is ignored when the value is greater than the current last-index value.
- R12: A write of a last-index register (offset 0x00 for transmit, 0x03 for receive) sets the bound and clears both indices of that ring. A value of DEPTH or more is ignored.
- R13: A read request returns `reg_rvalid` and `reg_rdata` one cycle later. Registers: 0x00 transmit last, 0x01 transmit produce, 0x02 transmit consume, 0x03 receive last, 0x04 receive produce (read-only), 0x05 receive consume, 0x06 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Region in bits 7:5, slot or register offset in bits 4:0 |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after request |
| reg_rdata | output | 32 | Read data |
| tx_hw_done | input | 1 | Hardware finished the transmit slot at the consume index |
| tx_hw_status | input | 32 | Status word for the finished transmit slot |
| rx_hw_done | input | 1 | Hardware finished the receive slot at the produce index |
| rx_hw_status | input | 32 | Receive status word (length minus one in 10:0, error flags) |
| rx_hw_crc | input | 32 | Receive hash/CRC word |
| tx_full | output | 1 | Transmit ring full |
| tx_empty | output | 1 | Transmit ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_empty | output | 1 | Receive ring empty |
| tx_buf_ptr | output | 32 | Buffer pointer of the current transmit slot |
| tx_buf_len | output | 12 | Byte length of the current transmit slot |
| tx_last_frag | output | 1 | Current transmit slot ends a frame |
| rx_buf_ptr | output | 32 | Buffer pointer of the current receive slot |
| rx_buf_len | output | 12 | Buffer length of the current receive slot |
| rx_irq_req | output | 1 | Current receive slot requests an interrupt |
| rx_done | output | 1 | Pulse: receive produce index advanced |
| rx_irq | output | 1 | Pulse: completed receive slot requested an interrupt |
| rx_err | output | 1 | Pulse: completed receive slot had an error flag |

## Verification
The bench fills both rings until they are full and drains them until they are empty. A design that compared the wrong pair of indices would report full one slot early or late, or would let a completion strobe move past the other side's index. The bench drives indices across the wrap point at a reduced bound, which catches a design that wraps at the memory depth instead of at the programmed value. It issues writes above the bound and writes to the indices software does not own, and a design that let either through would read back a moved index. It checks that the receive empty flag stays set for the cycle after a completion and clears only on the next one. It uses a status with only the range-error bit set, which shows whether the error mask was applied correctly.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int SIZE_W   = 11;          // length-minus-one field, bits 10:0
  localparam int LEN_W    = SIZE_W + 1;  // decoded byte length
  localparam int TX_LAST_BIT = 30;       // last fragment flag in transmit control
  localparam int RX_IRQ_BIT  = 31;       // interrupt request in receive control
  localparam logic [DATA_W-1:0] RX_ERR_MASK = 32'h1B80_0000;

  // region selected by reg_addr[7:5]
  typedef enum logic [2:0] {
    RGN_CTRL  = 3'd0,
    RGN_TXPTR = 3'd1,
    RGN_TXCTL = 3'd2,
    RGN_RXPTR = 3'd3,
    RGN_RXCTL = 3'd4,
    RGN_TXST  = 3'd5,
    RGN_RXST0 = 3'd6,
    RGN_RXST1 = 3'd7
  } rgn_e;

  // register offsets inside RGN_CTRL
  localparam logic [4:0] OFS_TX_LAST = 5'd0;
  localparam logic [4:0] OFS_TX_PROD = 5'd1;
  localparam logic [4:0] OFS_TX_CONS = 5'd2;
  localparam logic [4:0] OFS_RX_LAST = 5'd3;
  localparam logic [4:0] OFS_RX_PROD = 5'd4;
  localparam logic [4:0] OFS_RX_CONS = 5'd5;
  localparam logic [4:0] OFS_FLAGS   = 5'd6;
endpackage

// File: rtl/dring_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module dring_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dring_index.sv
// Produce/consume index pair for one ring. SW_PROD selects which side
// software owns; the other side is advanced by hardware.
module dring_index #(
  parameter int DEPTH   = 8,
  parameter bit SW_PROD = 1'b1,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_val,
  input  logic             sw_wr,
  input  logic [31:0]      sw_val,
  input  logic             hw_adv,
  output logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] prod,
  output logic [IDX_W-1:0] cons,
  output logic             full,
  output logic             empty
);
  logic [IDX_W-1:0] last_q, prod_q, cons_q;
  logic cfg_ok, sw_ok;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v,
                                            input logic [IDX_W-1:0] lim);
    return (v == lim) ? '0 : v + IDX_W'(1);
  endfunction

  assign cfg_ok = cfg_wr && (cfg_val < 32'(DEPTH));
  assign sw_ok  = sw_wr && (sw_val <= 32'(last_q));
  assign full   = (step(prod_q, last_q) == cons_q);
  assign empty  = (prod_q == cons_q);

  always_ff @(posedge clk) begin
    if (rst)         last_q <= IDX_W'(DEPTH - 1);
    else if (cfg_ok) last_q <= cfg_val[IDX_W-1:0];
  end

  generate
    if (SW_PROD) begin : g_sw_prod
      // software posts, hardware drains
      always_ff @(posedge clk) begin
        if (rst || cfg_ok) prod_q <= '0;
        else if (sw_ok)    prod_q <= sw_val[IDX_W-1:0];
      end
      always_ff @(posedge clk) begin
        if (rst || cfg_ok)       cons_q <= '0;
        else if (hw_adv && !empty) cons_q <= step(cons_q, last_q);
      end
    end else begin : g_hw_prod
      // hardware fills, software drains
      always_ff @(posedge clk) begin
        if (rst || cfg_ok)        prod_q <= '0;
        else if (hw_adv && !full) prod_q <= step(prod_q, last_q);
      end
      always_ff @(posedge clk) begin
        if (rst || cfg_ok) cons_q <= '0;
        else if (sw_ok)    cons_q <= sw_val[IDX_W-1:0];
      end
    end
  endgenerate

  assign last_idx = last_q;
  assign prod     = prod_q;
  assign cons     = cons_q;
endmodule

// File: rtl/dring_decode.sv
// Turns a stored {flag, size-minus-one} control field into length and flag.
module dring_decode #(
  parameter int SIZE_W = 11,
  localparam int LEN_W = SIZE_W + 1
) (
  input  logic [SIZE_W:0]  field,
  output logic [LEN_W-1:0] len,
  output logic             flag
);
  assign len  = LEN_W'(field[SIZE_W-1:0]) + LEN_W'(1);
  assign flag = field[SIZE_W];
endmodule

// File: rtl/dring_tracker.sv
module dring_tracker
  import dring_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_hw_done,
  input  logic [DATA_W-1:0] tx_hw_status,
  input  logic              rx_hw_done,
  input  logic [DATA_W-1:0] rx_hw_status,
  input  logic [DATA_W-1:0] rx_hw_crc,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [DATA_W-1:0] tx_buf_ptr,
  output logic [LEN_W-1:0]  tx_buf_len,
  output logic              tx_last_frag,
  output logic [DATA_W-1:0] rx_buf_ptr,
  output logic [LEN_W-1:0]  rx_buf_len,
  output logic              rx_irq_req,
  output logic              rx_done,
  output logic              rx_irq,
  output logic              rx_err
);
  localparam int FLD_W = SIZE_W + 1;

  // ---------------- register bus decode ----------------
  rgn_e             rgn;
  logic [4:0]       ofs;
  logic [IDX_W-1:0] slot;
  logic             slot_ok, wr, rd;
  logic             ctl_wr;

  assign rgn     = rgn_e'(reg_addr[ADDR_W-1 -: 3]);
  assign ofs     = reg_addr[4:0];
  assign slot    = reg_addr[IDX_W-1:0];
  assign slot_ok = ((reg_addr[4:0] >> IDX_W) == 5'd0);
  assign wr      = reg_valid && reg_write;
  assign rd      = reg_valid && !reg_write;
  assign ctl_wr  = wr && (rgn == RGN_CTRL);

  logic tx_cfg_wr, rx_cfg_wr, tx_sw_wr, rx_sw_wr;
  assign tx_cfg_wr = ctl_wr && (ofs == OFS_TX_LAST);
  assign rx_cfg_wr = ctl_wr && (ofs == OFS_RX_LAST);
  assign tx_sw_wr  = ctl_wr && (ofs == OFS_TX_PROD);
  assign rx_sw_wr  = ctl_wr && (ofs == OFS_RX_CONS);

  // ---------------- ring indices ----------------
  logic [IDX_W-1:0] tx_last_idx, tx_prod, tx_cons;
  logic [IDX_W-1:0] rx_last_idx, rx_prod, rx_cons;
  logic             rx_pend;

  dring_index #(.DEPTH(DEPTH), .SW_PROD(1'b1)) u_tx_idx (
    .clk, .rst,
    .cfg_wr(tx_cfg_wr), .cfg_val(reg_wdata),
    .sw_wr(tx_sw_wr),   .sw_val(reg_wdata),
    .hw_adv(tx_hw_done),
    .last_idx(tx_last_idx), .prod(tx_prod), .cons(tx_cons),
    .full(tx_full), .empty(tx_empty)
  );

  dring_index #(.DEPTH(DEPTH), .SW_PROD(1'b0)) u_rx_idx (
    .clk, .rst,
    .cfg_wr(rx_cfg_wr), .cfg_val(reg_wdata),
    .sw_wr(rx_sw_wr),   .sw_val(reg_wdata),
    .hw_adv(rx_pend),
    .last_idx(rx_last_idx), .prod(rx_prod), .cons(rx_cons),
    .full(rx_full), .empty(rx_empty)
  );

  // ---------------- completion handling ----------------
  logic tx_accept, rx_accept, pend_err;
  assign tx_accept = tx_hw_done && !tx_empty;
  assign rx_accept = rx_hw_done && !rx_full && !rx_pend;

  // receive: status stored at accept edge, index advances one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pend  <= 1'b0;
      pend_err <= 1'b0;
      rx_done  <= 1'b0;
      rx_irq   <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_pend  <= rx_accept;
      if (rx_accept) pend_err <= |(rx_hw_status & RX_ERR_MASK);
      rx_done  <= rx_pend;
      rx_irq   <= rx_pend && rx_irq_req;
      rx_err   <= rx_pend && pend_err;
    end
  end

  // ---------------- descriptor and status memories ----------------
  typedef struct packed {
    logic we;
    logic [IDX_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [IDX_W-1:0] raddr;
  } wide_port_t;

  localparam int NWIDE = 5;  // tx ptr, rx ptr, tx status, rx status, rx crc
  wide_port_t        wp [NWIDE];
  logic [DATA_W-1:0] wq [NWIDE];

  always_comb begin
    wp[0] = '{we: wr && slot_ok && (rgn == RGN_TXPTR), waddr: slot,
              wdata: reg_wdata, raddr: tx_cons};
    wp[1] = '{we: wr && slot_ok && (rgn == RGN_RXPTR), waddr: slot,
              wdata: reg_wdata, raddr: rx_prod};
    wp[2] = '{we: tx_accept, waddr: tx_cons, wdata: tx_hw_status, raddr: slot};
    wp[3] = '{we: rx_accept, waddr: rx_prod, wdata: rx_hw_status, raddr: slot};
    wp[4] = '{we: rx_accept, waddr: rx_prod, wdata: rx_hw_crc,    raddr: slot};
  end

  for (genvar i = 0; i < NWIDE; i++) begin : g_wide
    dring_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk, .we(wp[i].we), .waddr(wp[i].waddr), .wdata(wp[i].wdata),
      .raddr(wp[i].raddr), .rdata(wq[i])
    );
  end

  // control words keep only {flag, size-minus-one}
  logic [FLD_W-1:0] tx_fld_q, rx_fld_q;

  dring_ram #(.W(FLD_W), .DEPTH(DEPTH)) u_tx_ctl (
    .clk, .we(wr && slot_ok && (rgn == RGN_TXCTL)), .waddr(slot),
    .wdata({reg_wdata[TX_LAST_BIT], reg_wdata[SIZE_W-1:0]}),
    .raddr(tx_cons), .rdata(tx_fld_q)
  );

  dring_ram #(.W(FLD_W), .DEPTH(DEPTH)) u_rx_ctl (
    .clk, .we(wr && slot_ok && (rgn == RGN_RXCTL)), .waddr(slot),
    .wdata({reg_wdata[RX_IRQ_BIT], reg_wdata[SIZE_W-1:0]}),
    .raddr(rx_prod), .rdata(rx_fld_q)
  );

  dring_decode #(.SIZE_W(SIZE_W)) u_tx_dec (
    .field(tx_fld_q), .len(tx_buf_len), .flag(tx_last_frag)
  );
  dring_decode #(.SIZE_W(SIZE_W)) u_rx_dec (
    .field(rx_fld_q), .len(rx_buf_len), .flag(rx_irq_req)
  );

  assign tx_buf_ptr = wq[0];
  assign rx_buf_ptr = wq[1];

  // ---------------- register read path ----------------
  logic [DATA_W-1:0] scalar_d, scalar_q;
  rgn_e              rd_rgn;

  always_comb begin
    scalar_d = '0;
    if (rgn == RGN_CTRL) begin
      case (ofs)
        OFS_TX_LAST: scalar_d = 32'(tx_last_idx);
        OFS_TX_PROD: scalar_d = 32'(tx_prod);
        OFS_TX_CONS: scalar_d = 32'(tx_cons);
        OFS_RX_LAST: scalar_d = 32'(rx_last_idx);
        OFS_RX_PROD: scalar_d = 32'(rx_prod);
        OFS_RX_CONS: scalar_d = 32'(rx_cons);
        OFS_FLAGS:   scalar_d = {28'd0, rx_empty, rx_full, tx_empty, tx_full};
        default:     scalar_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      scalar_q   <= '0;
      rd_rgn     <= RGN_CTRL;
    end else begin
      reg_rvalid <= rd;
      if (rd) begin
        scalar_q <= scalar_d;
        rd_rgn   <= slot_ok ? rgn : RGN_CTRL;
      end
    end
  end

  always_comb begin
    case (rd_rgn)
      RGN_TXST:  reg_rdata = wq[2];
      RGN_RXST0: reg_rdata = wq[3];
      RGN_RXST1: reg_rdata = wq[4];
      default:   reg_rdata = scalar_q;
    endcase
  end
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_hw_done,
  input logic             rx_hw_done,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             rx_pend,
  input logic             tx_cfg_wr,
  input logic             rx_cfg_wr,
  input logic [IDX_W-1:0] tx_last_idx,
  input logic [IDX_W-1:0] tx_prod,
  input logic [IDX_W-1:0] tx_cons,
  input logic [IDX_W-1:0] rx_last_idx,
  input logic [IDX_W-1:0] rx_prod,
  input logic [IDX_W-1:0] rx_cons
);
  // R11
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_prod <= tx_last_idx) && (tx_cons <= tx_last_idx) &&
    (rx_prod <= rx_last_idx) && (rx_cons <= rx_last_idx));

  // R5
  tx_empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_hw_done && tx_empty && !tx_cfg_wr |=> tx_cons == $past(tx_cons));

  // R3
  tx_cons_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_hw_done && !tx_cfg_wr |=> $stable(tx_cons));

  // R4
  rx_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_hw_done && rx_full && !rx_pend && !rx_cfg_wr |=> $stable(rx_prod));

  // R9
  rx_prod_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_pend && !rx_cfg_wr |=> $stable(rx_prod));

  // R9
  rx_prod_step_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pend && !rx_cfg_wr |=>
      rx_prod == (($past(rx_prod) == $past(rx_last_idx)) ? '0 : $past(rx_prod) + IDX_W'(1)));

  // R4
  rx_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_last_idx != '0) |-> !(rx_full && rx_empty));

  // R5
  tx_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_last_idx != '0) |-> !(tx_full && tx_empty));
endmodule

bind dring_tracker dring_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_dring_tracker.sv
module tb_dring_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        tx_hw_done = 1'b0, rx_hw_done = 1'b0;
  logic [31:0] tx_hw_status = '0, rx_hw_status = '0, rx_hw_crc = '0;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic [31:0] tx_buf_ptr, rx_buf_ptr;
  logic [11:0] tx_buf_len, rx_buf_len;
  logic        tx_last_frag, rx_irq_req, rx_done, rx_irq, rx_err;

  always #4 clk = ~clk;  // 125 MHz

  dring_tracker dut (.*);

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] A_TXLAST = 8'h00, A_TXPROD = 8'h01, A_TXCONS = 8'h02,
                         A_RXLAST = 8'h03, A_RXPROD = 8'h04, A_RXCONS = 8'h05,
                         A_FLAGS = 8'h06, A_TXPTR = 8'h20, A_TXCTL = 8'h40,
                         A_RXPTR = 8'h60, A_RXCTL = 8'h80, A_TXST = 8'hA0,
                         A_RXST0 = 8'hC0, A_RXST1 = 8'hE0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  // driver: issue a read and push the expected value for the monitor
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  // monitor: compare each returned read with the queued expectation
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R13 unexpected read data act=%h exp=none", reg_rdata);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic tx_complete(logic [31:0] st);
    @(negedge clk);
    tx_hw_done = 1'b1; tx_hw_status = st;
    @(negedge clk);
    tx_hw_done = 1'b0;
  endtask

  task automatic rx_complete(logic [31:0] st, logic [31:0] crc, logic e_mid,
                             logic e_after, logic e_done, logic e_irq,
                             logic e_err, string tag);
    @(negedge clk);
    rx_hw_done = 1'b1; rx_hw_status = st; rx_hw_crc = crc;
    @(negedge clk);
    rx_hw_done = 1'b0;
    chk({tag, " R9 empty after store edge"}, 32'(rx_empty), 32'(e_mid));
    @(negedge clk);
    chk({tag, " R9 empty after advance edge"}, 32'(rx_empty), 32'(e_after));
    chk({tag, " R9 rx_done"}, 32'(rx_done), 32'(e_done));
    chk({tag, " R7 rx_irq"}, 32'(rx_irq), 32'(e_irq));
    chk({tag, " R10 rx_err"}, 32'(rx_err), 32'(e_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 rx_empty", 32'(rx_empty), 1);
    chk("R1 tx_full", 32'(tx_full), 0);
    chk("R1 rx_full", 32'(rx_full), 0);
    rd(A_TXLAST, 7, "R1 tx last");
    rd(A_RXLAST, 7, "R1 rx last");
    rd(A_TXPROD, 0, "R1 tx prod");
    rd(A_RXCONS, 0, "R1 rx cons");
    rd(A_FLAGS, 32'hA, "R1 flags");

    // R12 ring size programming
    wr(A_TXLAST, 3);
    rd(A_TXLAST, 3, "R12 tx last set");
    wr(A_TXLAST, 9);
    rd(A_TXLAST, 3, "R12 tx last out of range ignored");
    wr(A_RXLAST, 3);

    // R6 transmit descriptors: lengths 60,70,80,90; slots 1,3 end a frame
    for (int i = 0; i < 4; i++) begin
      wr(A_TXPTR + 8'(i), 32'h1000 + 32'(i) * 32'h100);
      wr(A_TXCTL + 8'(i), ((i % 2 == 1) ? 32'h4000_0000 : 32'h0) | 32'(59 + 10 * i));
    end
    idle(2);
    chk("R6 tx ptr slot0", tx_buf_ptr, 32'h1000);
    chk("R6 tx len slot0", 32'(tx_buf_len), 60);
    chk("R6 tx last slot0", 32'(tx_last_frag), 0);

    // R3 / R5 / R11 posting
    wr(A_TXPROD, 1);
    chk("R5 tx not empty", 32'(tx_empty), 0);
    wr(A_TXPROD, 3);
    chk("R5 tx full", 32'(tx_full), 1);
    wr(A_TXPROD, 5);
    rd(A_TXPROD, 3, "R11 tx prod above bound ignored");
    wr(A_TXCONS, 2);
    rd(A_TXCONS, 0, "R3 tx cons not software writable");
    rd(A_FLAGS, 32'h9, "R13 flags tx full rx empty");

    // R3 / R8 hardware drain
    tx_complete(32'h0000_0011);
    idle(1);
    chk("R6 tx ptr slot1", tx_buf_ptr, 32'h1100);
    chk("R6 tx len slot1", 32'(tx_buf_len), 70);
    chk("R6 tx last slot1", 32'(tx_last_frag), 1);
    chk("R5 tx full cleared", 32'(tx_full), 0);
    tx_complete(32'h0000_0022);
    tx_complete(32'h0000_0033);
    chk("R5 tx empty after drain", 32'(tx_empty), 1);
    tx_complete(32'h0000_0044);
    rd(A_TXCONS, 3, "R5 completion on empty ignored");
    rd(A_TXST + 8'd0, 32'h11, "R8 tx status slot0");
    rd(A_TXST + 8'd1, 32'h22, "R8 tx status slot1");
    rd(A_TXST + 8'd2, 32'h33, "R8 tx status slot2");

    // R2 wrap on transmit
    wr(A_TXPROD, 0);
    idle(1);
    chk("R6 tx len slot3", 32'(tx_buf_len), 90);
    tx_complete(32'h0000_0055);
    rd(A_TXCONS, 0, "R2 tx cons wraps");
    chk("R2 tx empty after wrap", 32'(tx_empty), 1);
    rd(A_TXST + 8'd3, 32'h55, "R8 tx status slot3");

    // R7 receive descriptors: length 1536, only slot 0 requests interrupt
    for (int i = 0; i < 4; i++) begin
      wr(A_RXPTR + 8'(i), 32'h8000 + 32'(i) * 32'h800);
      wr(A_RXCTL + 8'(i), ((i == 0) ? 32'h8000_0000 : 32'h0) | 32'h5FF);
    end
    idle(2);
    chk("R7 rx ptr slot0", rx_buf_ptr, 32'h8000);
    chk("R7 rx len slot0", 32'(rx_buf_len), 1536);
    chk("R7 rx irq req slot0", 32'(rx_irq_req), 1);

    rx_complete(32'h0000_03FF, 32'h1234_5678, 1, 0, 1, 1, 0, "slot0");
    rd(A_RXPROD, 1, "R4 rx prod after one");
    rd(A_RXST0 + 8'd0, 32'h0000_03FF, "R8 rx status slot0");
    rd(A_RXST1 + 8'd0, 32'h1234_5678, "R8 rx crc slot0");
    chk("R7 rx ptr slot1", rx_buf_ptr, 32'h8800);
    rx_complete(32'h0400_0040, 32'h0, 0, 0, 1, 0, 0, "slot1 range only R10");
    rx_complete(32'h0800_0020, 32'h0, 0, 0, 1, 0, 1, "slot2 error R10");
    chk("R4 rx full", 32'(rx_full), 1);
    rx_complete(32'h0000_0001, 32'h0, 0, 0, 0, 0, 0, "full R4");
    rd(A_RXPROD, 3, "R4 completion on full ignored");
    wr(A_RXPROD, 0);
    rd(A_RXPROD, 3, "R13 rx prod read-only");

    // software drain of receive ring
    wr(A_RXCONS, 2);
    chk("R4 rx full cleared", 32'(rx_full), 0);
    wr(A_RXCONS, 7);
    rd(A_RXCONS, 2, "R11 rx cons above bound ignored");
    wr(A_RXCONS, 3);
    chk("R4 rx empty", 32'(rx_empty), 1);
    rx_complete(32'h0000_0010, 32'h0, 1, 0, 1, 0, 0, "slot3");
    rd(A_RXPROD, 0, "R2 rx prod wraps");

    // R12 resizing clears indices
    wr(A_RXLAST, 9);
    rd(A_RXLAST, 3, "R12 rx last out of range ignored");
    wr(A_RXLAST, 5);
    rd(A_RXLAST, 5, "R12 rx last set");
    rd(A_RXCONS, 0, "R12 rx cons cleared");
    chk("R12 rx empty after resize", 32'(rx_empty), 1);

    idle(4);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R13 missing reads act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule